// File: doc/BRIEF.md
# Counter Access Alias and Read-Index Decoder

This block sits between software accesses and an array of performance counters. It does not store the counters or count events. It decodes each access, shapes the write data and checks it. It then either issues a single write strobe to the counter array or returns read data taken from the array's current values.

Each general-purpose counter can be written through two aliases:

- **Narrow alias.** Only the low 32 bits of the write word are used. Those bits are sign-extended to the general-purpose counter width.
- **Wide alias.** The data is stored at full counter width. A word that does not fit the width is refused.

Reads use a 32-bit index word:

- Bit 30 chooses the fixed-counter group.
- Bit 31 asks for a fast read, which returns only the low 32 bits.
- Bits 29:0 pick the counter within the chosen group.

Any access that names a counter that does not exist, or carries a value too wide for its alias, raises a one-cycle fault flag and leaves the counter array untouched.

Top module: `ctr_access_port`

## Requirements
- R1: During and after reset, with no requests, `ctr_we`, `rd_valid`, `wr_fault` and `rd_fault` are 0. `rd_data` and `ctr_wdata` are also 0.
- R2: A narrow-alias write (`wr_full`=0) to an existing counter behaves as follows:
  - One cycle after the request, `ctr_we` pulses.
  - `ctr_sel` equals `wr_sel`.
  - `ctr_wdata` equals `wr_data[31:0]` sign-extended from bit 31 to GP_W bits.
  - `wr_data[63:32]` has no effect.
- R3: A wide-alias write (`wr_full`=1) whose data fits in GP_W bits produces `ctr_we` one cycle later, with `ctr_wdata` equal to the data. A later normal read of that counter returns the same value, whichever alias wrote it.
- R4: A wide-alias write with any of `wr_data[63:GP_W]` set raises `wr_fault` one cycle later and produces no `ctr_we`. The stored counter keeps its old value.
- R5: A write whose `wr_sel` is NUM_GP or above raises `wr_fault` one cycle later and produces no `ctr_we`.
- R6: A normal read (`rd_index[31]`=0) is decoded as follows:
  - `rd_index[30]`=0 selects general-purpose counter `rd_index[29:0]`.
  - `rd_index[30]`=1 selects fixed counter `rd_index[29:0]`.
  - One cycle after the request, `rd_valid` pulses and `rd_data` holds the selected value zero-extended to 64 bits.
- R7: A fast read (`rd_index[31]`=1) returns the low 32 bits of the selected counter in `rd_data[31:0]`, with `rd_data[63:32]` zero.
- R8: A read whose index names a counter that does not exist in its group raises `rd_fault` one cycle later. Examples are 64, or bit 30 set with a number of NUM_FX or above. `rd_valid` stays low and `rd_data` is 0.
- R9: Fixed and general-purpose counters have separate widths, FX_W and GP_W. A read returns a value no wider than the width of the selected group.
- R10: Each fault flag is a one-cycle pulse per faulting request. It is low in the cycle after a faulting request if no new faulting request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write request |
| wr_full | input | 1 | 1 = wide alias, 0 = narrow 32-bit alias |
| wr_sel | input | SEL_W | General-purpose counter number to write |
| wr_data | input | 64 | Write word |
| rd_req | input | 1 | Read request |
| rd_index | input | 32 | Read index: bit 31 fast, bit 30 fixed group, bits 29:0 counter |
| gp_vals | input | NUM_GP*GP_W | Current general-purpose counter values, counter 0 in the low bits |
| fx_vals | input | NUM_FX*FX_W | Current fixed counter values, counter 0 in the low bits |
| ctr_we | output | 1 | Write strobe to the counter array |
| ctr_sel | output | SEL_W | Counter written |
| ctr_wdata | output | GP_W | Shaped write value |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| wr_fault | output | 1 | Write refused |
| rd_fault | output | 1 | Read refused |

## Verification
On every cycle, the assertions check several properties:

- A fault and its matching success strobe never appear together.
- Every write strobe follows a write request.
- Every narrow-alias value is a proper sign extension of bit 31.
- Every wide-alias value equals the requested word.
- Every fast read has a zero upper half.

The bench scenarios cover what depends on the counter contents and on the exact index layout:

- The actual sign-extended and read-back values.
- The choice of group and counter.
- The masking to each group's width.
- Whether a refused wide write really left the stored value intact.

// File: rtl/ctr_access_port.sv
module ctr_access_port #(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 48,
  parameter int FX_W   = 40,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_req,
  input  logic                     wr_full,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [63:0]              wr_data,
  input  logic                     rd_req,
  input  logic [31:0]              rd_index,
  input  logic [NUM_GP*GP_W-1:0]   gp_vals,
  input  logic [NUM_FX*FX_W-1:0]   fx_vals,
  output logic                     ctr_we,
  output logic [SEL_W-1:0]         ctr_sel,
  output logic [GP_W-1:0]          ctr_wdata,
  output logic                     rd_valid,
  output logic [63:0]              rd_data,
  output logic                     wr_fault,
  output logic                     rd_fault
);

  localparam logic [63:0] GP_MASK = (GP_W >= 64) ? '1 : ((64'd1 << GP_W) - 64'd1);

  logic            sel_ok, wide_bad, wr_good;
  logic [63:0]     sext32;
  logic [GP_W-1:0] shaped;

  assign sel_ok   = 32'(wr_sel) < NUM_GP;
  assign wide_bad = wr_full && ((wr_data & ~GP_MASK) != 64'd0);
  assign wr_good  = sel_ok && !wide_bad;
  assign sext32   = {{32{wr_data[31]}}, wr_data[31:0]};
  assign shaped   = wr_full ? wr_data[GP_W-1:0] : sext32[GP_W-1:0];

  logic        rd_fast, rd_fixed, rd_ok;
  logic [29:0] rd_num;
  logic [63:0] sel_val;

  assign rd_fast  = rd_index[31];
  assign rd_fixed = rd_index[30];
  assign rd_num   = rd_index[29:0];
  assign rd_ok    = rd_fixed ? (32'(rd_num) < NUM_FX) : (32'(rd_num) < NUM_GP);

  always_comb begin
    sel_val = 64'd0;
    if (rd_fixed) begin
      for (int i = 0; i < NUM_FX; i++)
        if (32'(rd_num) == i) sel_val = 64'(fx_vals[i*FX_W +: FX_W]);
    end else begin
      for (int i = 0; i < NUM_GP; i++)
        if (32'(rd_num) == i) sel_val = 64'(gp_vals[i*GP_W +: GP_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr_we    <= 1'b0;
      ctr_sel   <= '0;
      ctr_wdata <= '0;
      wr_fault  <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= 64'd0;
      rd_fault  <= 1'b0;
    end else begin
      ctr_we    <= wr_req && wr_good;
      wr_fault  <= wr_req && !wr_good;
      if (wr_req && wr_good) begin
        ctr_sel   <= wr_sel;
        ctr_wdata <= shaped;
      end
      rd_valid  <= rd_req && rd_ok;
      rd_fault  <= rd_req && !rd_ok;
      if (rd_req && rd_ok)
        rd_data <= rd_fast ? {32'd0, sel_val[31:0]} : sel_val;
      else
        rd_data <= 64'd0;
    end
  end

  // R4 R5
  wr_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> !ctr_we);

  // R2
  we_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_we |-> $past(wr_req));

  // R2
  narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_we && !$past(wr_full)) |->
      ((ctr_wdata[GP_W-1:31] == '0) || (ctr_wdata[GP_W-1:31] == '1)));

  // R3
  wide_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_we && $past(wr_full)) |-> (ctr_wdata == $past(wr_data[GP_W-1:0])));

  // R7
  fast_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_index[31])) |-> (rd_data[63:32] == 32'd0));

  // R8
  rd_fault_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |-> (!rd_valid && rd_data == 64'd0));

endmodule

// File: tb/ctr_access_port_test.sv
`timescale 1ns/1ps
module ctr_access_port_test;
  localparam int NUM_GP = 4, NUM_FX = 3, GP_W = 48, FX_W = 40, SEL_W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic wr_req = 0, wr_full = 0, rd_req = 0;
  logic [SEL_W-1:0] wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [31:0] rd_index = '0;
  logic [GP_W-1:0] gp_mem [NUM_GP];
  logic [FX_W-1:0] fx_mem [NUM_FX];
  logic [NUM_GP*GP_W-1:0] gp_vals;
  logic [NUM_FX*FX_W-1:0] fx_vals;
  logic ctr_we, rd_valid, wr_fault, rd_fault;
  logic [SEL_W-1:0] ctr_sel;
  logic [GP_W-1:0] ctr_wdata;
  logic [63:0] rd_data;

  always_comb begin
    for (int i = 0; i < NUM_GP; i++) gp_vals[i*GP_W +: GP_W] = gp_mem[i];
    for (int i = 0; i < NUM_FX; i++) fx_vals[i*FX_W +: FX_W] = fx_mem[i];
  end

  initial begin
    for (int i = 0; i < NUM_GP; i++) gp_mem[i] = GP_W'(64'h1111_0000_0000 * (i + 1));
    fx_mem[0] = 40'h12_3456_789A;
    fx_mem[1] = 40'hFE_DCBA_9876;
    fx_mem[2] = 40'h00_0000_0042;
  end

  always @(posedge clk) if (ctr_we) gp_mem[ctr_sel] <= ctr_wdata;

  ctr_access_port #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W), .SEL_W(SEL_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_full(wr_full), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_req(rd_req), .rd_index(rd_index), .gp_vals(gp_vals),
    .fx_vals(fx_vals), .ctr_we(ctr_we), .ctr_sel(ctr_sel), .ctr_wdata(ctr_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_fault(wr_fault), .rd_fault(rd_fault));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input bit full, input int sel, input logic [63:0] d,
                          input bit exp_ok, input logic [GP_W-1:0] exp_val, input string tag);
    @(negedge clk);
    wr_req = 1; wr_full = full; wr_sel = SEL_W'(sel); wr_data = d;
    @(negedge clk);
    wr_req = 0;
    chk(ctr_we == exp_ok, {tag, " we"}, 64'(ctr_we), 64'(exp_ok));
    chk(wr_fault == !exp_ok, {tag, " fault"}, 64'(wr_fault), 64'(!exp_ok));
    if (exp_ok) begin
      chk(ctr_wdata == exp_val, {tag, " data"}, 64'(ctr_wdata), 64'(exp_val));
      chk(ctr_sel == SEL_W'(sel), {tag, " sel"}, 64'(ctr_sel), 64'(sel));
    end
    @(negedge clk);
    // R10: fault does not persist
    chk(wr_fault == 0, "R10 wr_fault pulse", 64'(wr_fault), 64'd0);
  endtask

  task automatic do_read(input logic [31:0] idx, input bit exp_ok, input logic [63:0] exp_val,
                         input string tag);
    @(negedge clk);
    rd_req = 1; rd_index = idx;
    @(negedge clk);
    rd_req = 0;
    chk(rd_valid == exp_ok, {tag, " valid"}, 64'(rd_valid), 64'(exp_ok));
    chk(rd_fault == !exp_ok, {tag, " fault"}, 64'(rd_fault), 64'(!exp_ok));
    chk(rd_data == exp_val, {tag, " data"}, rd_data, exp_val);
    @(negedge clk);
    chk(rd_fault == 0, "R10 rd_fault pulse", 64'(rd_fault), 64'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk({ctr_we, rd_valid, wr_fault, rd_fault} == 4'b0, "R1 strobes in reset", 64'({ctr_we, rd_valid, wr_fault, rd_fault}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(rd_data == 0 && ctr_wdata == 0, "R1 data after reset", rd_data, 64'd0);
  endtask

  task automatic t_narrow;
    do_write(0, 0, 64'hFFFF_FF01_2345_6789, 1, 48'h0000_2345_6789, "R2 narrow positive");
    do_write(0, 1, 64'h0000_0000_89AB_CDEF, 1, 48'hFFFF_89AB_CDEF, "R2 narrow negative");
    do_read(32'd1, 1, 64'h0000_FFFF_89AB_CDEF, "R3 readback narrow");
  endtask

  task automatic t_wide;
    do_write(1, 2, 64'h0000_FF01_2345_6789, 1, 48'hFF01_2345_6789, "R3 wide write");
    do_read(32'd2, 1, 64'h0000_FF01_2345_6789, "R3 readback wide");
    do_read(32'h8000_0002, 1, 64'h0000_0000_2345_6789, "R7 fast gp");
  endtask

  task automatic t_bad_write;
    do_write(1, 2, 64'hFFFF_FF01_2345_6789, 0, '0, "R4 oversize wide");
    do_read(32'd2, 1, 64'h0000_FF01_2345_6789, "R4 counter unchanged");
    do_write(0, 4, 64'h1, 0, '0, "R5 bad select");
  endtask

  task automatic t_fixed;
    do_read(32'h4000_0001, 1, 64'h0000_00FE_DCBA_9876, "R6 R9 fixed read");
    do_read(32'h4000_0000, 1, 64'h0000_0012_3456_789A, "R6 fixed 0");
    do_read(32'hC000_0001, 1, 64'h0000_0000_DCBA_9876, "R7 fast fixed");
    do_read(32'd3, 1, 64'h0000_4444_0000_0000, "R9 gp width");
  endtask

  task automatic t_bad_read;
    do_read(32'd64, 0, 64'd0, "R8 index 64");
    do_read(32'h4000_0003, 0, 64'd0, "R8 fixed out of range");
    do_read(32'h8000_0004, 0, 64'd0, "R8 fast out of range");
  endtask

  initial begin
    t_reset();
    t_narrow();
    t_wide();
    t_bad_write();
    t_fixed();
    t_bad_read();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule